// File: doc/BRIEF.md
# Page-Mode External Memory Bus Controller

This block sequences the external memory bus of an 8-bit microcontroller core. It serves two kinds of request: instruction fetches and data transfers, where a data transfer is a read or a write. It remembers the upper address byte it last latched onto the external bus. For each new request it compares the upper byte of the new address with that remembered byte. If they match, the access is a page hit: only the low byte is driven and the strobe phase starts at once. If they differ, the access is a page miss: one address-latch cycle drives the upper byte on port 2 with ALE high, and the strobe phase follows.

A 2-bit page-mode field sets the strobe length and the hit policy. A 3-bit stretch count lengthens data strobes in steps of four clocks. A bus-arrangement input selects one of two layouts. In the first layout, data travels on port 0 and the low address byte goes on port 2. In the second layout, the low byte goes on port 0 and data shares port 2 with the upper byte. The second layout speeds up only instruction fetches, so its data transfers always use the non-page timing. The core issues a one-clock request pulse and waits for a one-clock done pulse.

Top module: `pgbus_ctrl`

## Requirements
- R1: After reset, ALE is low, all three strobes (`pstore_n`, `rd_n`, `wr_n`) are high, both port enables are low and `done` is low. The remembered upper byte is marked invalid, so the first access after reset is a page miss.
- R2: A page miss holds `ale` high for exactly one clock, with the upper address byte on `p2_out` and every strobe high. The strobe phase starts in the next clock. A page hit never raises `ale`.
- R3: In page modes 00, 01 and 10, an instruction fetch is a hit exactly when its upper address byte equals the upper byte latched by the most recent miss. A fetch whose upper byte differs is a miss.
- R4: In mode 00 (one-cycle), every strobe lasts one clock and every data transfer is a miss. The next instruction fetch after a data transfer is also a miss, even when its upper byte matches.
- R5: An instruction fetch strobes `pstore_n` low for 1, 2 or 4 clocks in modes 00, 01 and 10. In modes 01 and 10, a data transfer in the first layout follows the same upper-byte hit rule as a fetch.
- R6: In mode 11 (non-page), every access is a miss and the base strobe length is 4 clocks.
- R7: Each data strobe (`rd_n` or `wr_n`) is lengthened by 4 clocks for each unit of `stretch`. Instruction fetch strobes ignore `stretch`.
- R8: With `mux_arr`=1, the low address byte is on `p0_out` during the strobe. Write data and read data use port 2. Data transfers are always misses with a base length of 4 clocks.
- R9: With `mux_arr`=0, the low address byte is on `p2_out` during the strobe. Write data is driven on `p0_out` with `p0_oe` high, and read data comes from `p0_in`.
- R10: `done` is high for exactly one clock, in the clock after the last strobe clock. For reads and fetches, `rdata` then holds the data-port value sampled in the last strobe clock.
- R11: A request pulse that arrives while an access is in progress is ignored. No extra access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| page_sel | input | 2 | Page mode: 00 one-cycle, 01 two-cycle, 10 four-cycle, 11 non-page |
| mux_arr | input | 1 | 0: data on port 0; 1: upper byte and data share port 2 |
| stretch | input | 3 | Extra data strobe length in units of four clocks |
| req | input | 1 | One-clock request pulse, accepted when idle |
| req_data | input | 1 | 1: data transfer, 0: instruction fetch |
| req_wr | input | 1 | Write when `req_data` is 1 |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured read or fetch data |
| ale | output | 1 | Address latch enable |
| pstore_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Port 0 output value |
| p0_oe | output | 1 | Port 0 output enable |
| p0_in | input | 8 | Port 0 input value |
| p2_out | output | 8 | Port 2 output value |
| p2_oe | output | 1 | Port 2 output enable |
| p2_in | input | 8 | Port 2 input value |

## Verification
The bench counts ALE clocks and strobe clocks for every access and checks both counts against the expected miss or hit and the expected length.

- **Forced miss after a data transfer in one-cycle mode.** The bench fetches from a page that matches the remembered byte. A design that only compares addresses would report a hit there, with zero ALE clocks.
- **Stretch on a data hit and on a fetch.** A design that also stretches fetches, or that scales the count wrongly, shows a wrong strobe length.
- **Second layout.** Data must move to port 2 and data transfers must always miss. A design that keeps the page rule for data in that layout would skip the ALE clock.
- **Request during a long transfer.** A design that accepts it would start a second ALE or strobe after `done`.

// File: rtl/pgbus_pkg.sv
package pgbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MISS = 2'd1,
    ST_XFER = 2'd2
  } bus_st_e;

  localparam logic [1:0] PM_ONE  = 2'b00;
  localparam logic [1:0] PM_TWO  = 2'b01;
  localparam logic [1:0] PM_FOUR = 2'b10;
  localparam logic [1:0] PM_NONE = 2'b11;
endpackage

// File: rtl/pgbus_rst_sync.sv
module pgbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pgbus_page_track.sv
module pgbus_page_track
  import pgbus_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      page_sel,
  input  logic            mux_arr,
  input  logic            req_data,
  input  logic [HI_W-1:0] req_hi,
  input  logic            latch_en,
  input  logic            latch_data,
  input  logic [HI_W-1:0] latch_hi,
  input  logic            fin_data,
  output logic            hit
);
  logic [HI_W-1:0] hi_q, hi_d;
  logic            vld_q, vld_d;
  logic            force_q, force_d;

  always_comb begin
    hi_d    = hi_q;
    vld_d   = vld_q;
    force_d = force_q;
    if (latch_en) begin
      hi_d  = latch_hi;
      vld_d = 1'b1;
      if (!latch_data) force_d = 1'b0;
    end
    if (fin_data && page_sel == PM_ONE) force_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      vld_q   <= 1'b0;
      force_q <= 1'b0;
    end else begin
      if (latch_en) hi_q <= hi_d;
      vld_q   <= vld_d;
      force_q <= force_d;
    end
  end

  always_comb begin
    hit = vld_q && (req_hi == hi_q) && (page_sel != PM_NONE);
    if (req_data && (page_sel == PM_ONE || mux_arr)) hit = 1'b0;
    if (!req_data && page_sel == PM_ONE && force_q)  hit = 1'b0;
  end

  assert_latch_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |=> (vld_q && hi_q == $past(latch_hi)));
endmodule

// File: rtl/pgbus_seq.sv
module pgbus_seq
  import pgbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STR_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          page_sel,
  input  logic                mux_arr,
  input  logic [STR_W-1:0]    stretch,
  input  logic                req,
  input  logic                req_data,
  input  logic                req_wr,
  input  logic [2*DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                hit,
  input  logic [DATA_W-1:0]   din,
  output bus_st_e             st,
  output logic [2*DATA_W-1:0] addr,
  output logic [DATA_W-1:0]   wdata,
  output logic                is_data,
  output logic                is_wr,
  output logic                arr,
  output logic                fin_data,
  output logic                done,
  output logic [DATA_W-1:0]   rdata
);
  localparam int ADDR_W  = 2 * DATA_W;
  localparam int MAX_LEN = 4 * (1 << STR_W);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  bus_st_e             st_q, st_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d, len, base;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q, rdata_d;
  logic                data_q, wr_q, arr_q, done_q, done_d;
  logic                start, last, cap_en;

  assign start  = (st_q == ST_IDLE) && req;
  assign last   = (st_q == ST_XFER) && (cnt_q == '0);
  assign cap_en = last && !(data_q && wr_q);

  always_comb begin
    case (page_sel)
      PM_ONE:  base = CNT_W'(1);
      PM_TWO:  base = CNT_W'(2);
      default: base = CNT_W'(4);
    endcase
    if (req_data && mux_arr) base = CNT_W'(4);
    len = base + (req_data ? CNT_W'({stretch, 2'b00}) : '0);
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    rdata_d = rdata_q;
    case (st_q)
      ST_IDLE: if (req) begin
        st_d  = hit ? ST_XFER : ST_MISS;
        cnt_d = len - CNT_W'(1);
      end
      ST_MISS: st_d = ST_XFER;
      ST_XFER: begin
        if (cnt_q == '0) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          if (cap_en) rdata_d = din;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      data_q  <= 1'b0;
      wr_q    <= 1'b0;
      arr_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (start) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        data_q  <= req_data;
        wr_q    <= req_wr;
        arr_q   <= mux_arr;
      end
      if (cap_en) rdata_q <= rdata_d;
    end
  end

  assign st       = st_q;
  assign addr     = addr_q;
  assign wdata    = wdata_q;
  assign is_data  = data_q;
  assign is_wr    = wr_q;
  assign arr      = arr_q;
  assign fin_data = last && data_q;
  assign done     = done_q;
  assign rdata    = rdata_q;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(addr_q));
  assert_one_cyc_data_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && req_data && page_sel == PM_ONE) |=> (st_q == ST_MISS));
  assert_miss_then_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MISS) |=> (st_q == ST_XFER));
endmodule

// File: rtl/pgbus_port_mux.sv
module pgbus_port_mux
  import pgbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bus_st_e             st,
  input  logic [2*DATA_W-1:0] addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                is_data,
  input  logic                is_wr,
  input  logic                arr,
  input  logic [DATA_W-1:0]   p0_in,
  input  logic [DATA_W-1:0]   p2_in,
  output logic [DATA_W-1:0]   din,
  output logic                ale,
  output logic                pstore_n,
  output logic                rd_n,
  output logic                wr_n,
  output logic [DATA_W-1:0]   p0_out,
  output logic                p0_oe,
  output logic [DATA_W-1:0]   p2_out,
  output logic                p2_oe
);
  logic xfer, wr_xfer;

  assign xfer    = (st == ST_XFER);
  assign wr_xfer = xfer && is_data && is_wr;

  always_comb begin
    ale      = (st == ST_MISS);
    pstore_n = !(xfer && !is_data);
    rd_n     = !(xfer && is_data && !is_wr);
    wr_n     = !wr_xfer;
    p0_out   = '0;
    p0_oe    = 1'b0;
    p2_out   = '0;
    p2_oe    = 1'b0;
    if (st == ST_MISS) begin
      p2_out = addr[2*DATA_W-1:DATA_W];
      p2_oe  = 1'b1;
    end else if (xfer) begin
      if (arr) begin
        p0_out = addr[DATA_W-1:0];
        p0_oe  = 1'b1;
        p2_out = wdata;
        p2_oe  = wr_xfer;
      end else begin
        p2_out = addr[DATA_W-1:0];
        p2_oe  = 1'b1;
        p0_out = wdata;
        p0_oe  = wr_xfer;
      end
    end
    din = arr ? p2_in : p0_in;
  end

  assert_ale_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (pstore_n && rd_n && wr_n));
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!pstore_n, !rd_n, !wr_n}));
endmodule

// File: rtl/pgbus_ctrl.sv
module pgbus_ctrl
  import pgbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STR_W  = 3
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic [1:0]          page_sel,
  input  logic                mux_arr,
  input  logic [STR_W-1:0]    stretch,
  input  logic                req,
  input  logic                req_data,
  input  logic                req_wr,
  input  logic [2*DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  output logic                ale,
  output logic                pstore_n,
  output logic                rd_n,
  output logic                wr_n,
  output logic [DATA_W-1:0]   p0_out,
  output logic                p0_oe,
  input  logic [DATA_W-1:0]   p0_in,
  output logic [DATA_W-1:0]   p2_out,
  output logic                p2_oe,
  input  logic [DATA_W-1:0]   p2_in
);
  localparam int ADDR_W = 2 * DATA_W;

  logic              rst_n, hit, is_data, is_wr, arr, fin_data;
  bus_st_e           st;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, din;

  pgbus_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  pgbus_page_track #(.HI_W(DATA_W)) u_track (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .mux_arr(mux_arr),
    .req_data(req_data), .req_hi(req_addr[ADDR_W-1:DATA_W]),
    .latch_en(st == ST_MISS), .latch_data(is_data),
    .latch_hi(addr[ADDR_W-1:DATA_W]), .fin_data(fin_data), .hit(hit)
  );

  pgbus_seq #(.DATA_W(DATA_W), .STR_W(STR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .mux_arr(mux_arr),
    .stretch(stretch), .req(req), .req_data(req_data), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .hit(hit), .din(din),
    .st(st), .addr(addr), .wdata(wdata), .is_data(is_data), .is_wr(is_wr),
    .arr(arr), .fin_data(fin_data), .done(done), .rdata(rdata)
  );

  pgbus_port_mux #(.DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .st(st), .addr(addr), .wdata(wdata),
    .is_data(is_data), .is_wr(is_wr), .arr(arr), .p0_in(p0_in),
    .p2_in(p2_in), .din(din), .ale(ale), .pstore_n(pstore_n),
    .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe),
    .p2_out(p2_out), .p2_oe(p2_oe)
  );
endmodule

// File: tb/tb_pgbus_ctrl.sv
module tb_pgbus_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [1:0]  page_sel;
  logic        mux_arr;
  logic [2:0]  stretch;
  logic        req, req_data, req_wr;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        done;
  logic [7:0]  rdata;
  logic        ale, pstore_n, rd_n, wr_n, p0_oe, p2_oe;
  logic [7:0]  p0_out, p2_out, p0_in, p2_in;

  int checks = 0;
  int errors = 0;
  bit inject = 1'b0;

  always #10 clk = ~clk;

  pgbus_ctrl dut (
    .clk(clk), .rst_ni(rst_ni), .page_sel(page_sel), .mux_arr(mux_arr),
    .stretch(stretch), .req(req), .req_data(req_data), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .ale(ale), .pstore_n(pstore_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out),
    .p2_oe(p2_oe), .p2_in(p2_in)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // One access: counts ALE and strobe clocks, checks port contents each clock.
  task automatic run_acc(input bit d, input bit w, input logic [15:0] a,
                         input logic [7:0] wd, input bit exp_miss,
                         input int exp_len, input string rq);
    int n = 0;
    int ale_n = 0;
    int stb_n = 0;
    bit bad = 1'b0;
    logic [7:0] exp_rd;
    p0_in = 8'hA5 ^ a[7:0];
    p2_in = 8'h3C ^ a[7:0];
    exp_rd = mux_arr ? p2_in : p0_in;
    req = 1'b1; req_data = d; req_wr = w; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req = 1'b0;
    while (!done && n < 100) begin
      if (ale) begin
        ale_n++;
        if (p2_out !== a[15:8] || !p2_oe || !pstore_n || !rd_n || !wr_n) bad = 1'b1;
      end else begin
        if (d ? (w ? !wr_n : !rd_n) : !pstore_n) stb_n++;
        else bad = 1'b1;
        if (!d && (!rd_n || !wr_n)) bad = 1'b1;
        if (d && !pstore_n) bad = 1'b1;
        if (mux_arr) begin
          if (p0_out !== a[7:0] || !p0_oe) bad = 1'b1;
          if (d && w && (p2_out !== wd || !p2_oe)) bad = 1'b1;
          if (!(d && w) && p2_oe) bad = 1'b1;
        end else begin
          if (p2_out !== a[7:0] || !p2_oe) bad = 1'b1;
          if (d && w && (p0_out !== wd || !p0_oe)) bad = 1'b1;
          if (!(d && w) && p0_oe) bad = 1'b1;
        end
      end
      if (inject && n == 2) begin
        req = 1'b1; req_addr = 16'hFFFF; req_data = 1'b0;
      end else begin
        req = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    req = 1'b0;
    chk(done === 1'b1, {rq, " done seen R10"}, done, 1);
    chk(ale_n == (exp_miss ? 1 : 0), {rq, " ALE clocks R2"}, ale_n, exp_miss ? 1 : 0);
    chk(stb_n == exp_len, {rq, " strobe clocks"}, stb_n, exp_len);
    chk(!bad, {rq, " port contents R8 R9"}, bad, 0);
    if (!(d && w)) chk(rdata === exp_rd, {rq, " rdata R10"}, rdata, exp_rd);
    @(negedge clk);
    chk(done === 1'b0, {rq, " done one clock R10"}, done, 0);
  endtask

  task automatic cfg(input logic [1:0] pm, input bit arr, input logic [2:0] s);
    page_sel = pm; mux_arr = arr; stretch = s;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(ale === 1'b0 && pstore_n === 1'b1 && rd_n === 1'b1 && wr_n === 1'b1,
        "R1 strobes idle in reset", {ale, pstore_n, rd_n, wr_n}, 4'b0111);
    chk(done === 1'b0 && p0_oe === 1'b0 && p2_oe === 1'b0,
        "R1 done and enables low", {done, p0_oe, p2_oe}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_mode_one();
    cfg(2'b00, 1'b0, 3'd0);
    run_acc(0, 0, 16'h1200, 8'h00, 1, 1, "R1 first fetch miss");
    run_acc(0, 0, 16'h1201, 8'h00, 0, 1, "R3 R4 same page hit");
    run_acc(0, 0, 16'h1300, 8'h00, 1, 1, "R3 page change miss");
    run_acc(1, 0, 16'h1310, 8'h00, 1, 1, "R4 data read always miss");
    run_acc(0, 0, 16'h1320, 8'h00, 1, 1, "R4 forced fetch miss");
    run_acc(0, 0, 16'h1321, 8'h00, 0, 1, "R4 hit after forced miss");
    run_acc(1, 1, 16'h1330, 8'h5A, 1, 1, "R4 R9 data write miss");
  endtask

  task automatic t_mode_two();
    cfg(2'b01, 1'b0, 3'd0);
    run_acc(0, 0, 16'h5000, 8'h00, 1, 2, "R5 two-cycle fetch miss");
    run_acc(1, 0, 16'h5010, 8'h00, 0, 2, "R5 two-cycle data hit");
    run_acc(1, 1, 16'h6011, 8'hC3, 1, 2, "R5 R9 data page change miss");
  endtask

  task automatic t_mode_four();
    cfg(2'b10, 1'b0, 3'd0);
    run_acc(0, 0, 16'h4000, 8'h00, 1, 4, "R5 four-cycle fetch miss");
    run_acc(1, 0, 16'h4080, 8'h00, 0, 4, "R5 four-cycle data hit");
  endtask

  task automatic t_stretch();
    cfg(2'b01, 1'b0, 3'd2);
    inject = 1'b1;
    run_acc(1, 0, 16'h4040, 8'h00, 0, 10, "R7 R11 stretched read hit");
    inject = 1'b0;
    repeat (3) begin
      chk(ale === 1'b0 && pstore_n && rd_n && wr_n, "R11 no extra access",
          {ale, pstore_n, rd_n, wr_n}, 4'b0111);
      @(negedge clk);
    end
    run_acc(0, 0, 16'h4000, 8'h00, 0, 2, "R7 fetch not stretched");
    run_acc(1, 1, 16'h7000, 8'h99, 1, 10, "R7 stretched write miss");
  endtask

  task automatic t_no_page();
    cfg(2'b11, 1'b0, 3'd0);
    run_acc(0, 0, 16'h7000, 8'h00, 1, 4, "R6 non-page fetch miss");
    run_acc(0, 0, 16'h7001, 8'h00, 1, 4, "R6 non-page same page miss");
  endtask

  task automatic t_arr_b();
    cfg(2'b01, 1'b1, 3'd1);
    run_acc(0, 0, 16'h8000, 8'h00, 1, 2, "R8 second layout fetch miss");
    run_acc(0, 0, 16'h8004, 8'h00, 0, 2, "R8 second layout fetch hit");
    run_acc(1, 0, 16'h8010, 8'h00, 1, 8, "R8 second layout read miss");
    run_acc(1, 1, 16'h8020, 8'h6E, 1, 8, "R8 second layout write miss");
  endtask

  initial begin
    req = 0; req_data = 0; req_wr = 0; req_addr = '0; req_wdata = '0;
    p0_in = '0; p2_in = '0;
    cfg(2'b00, 1'b0, 3'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_one();
    t_mode_two();
    t_mode_four();
    t_stretch();
    t_no_page();
    t_arr_b();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule